// File: doc/BRIEF.md
# Sequential Fall-Through Run Table

This block remembers stretches of straight-line code that a thread has actually executed. A run opens at the target of a committed taken branch and closes at the next committed taken branch. It is counted only if at least one not-taken branch committed inside it. For every closed run, the table stores the address of the closing branch as the run's end address. A front end can then probe the table with a speculative taken-branch target and learn that a fall-through run lies ahead and where it ends.

The table is set associative. The low bits of the run's start address choose the set, and the remaining bits form the tag. Commits arrive one per cycle, in order, and each carries a thread number. Every thread keeps its own pointer to the run it is currently building, so commits from different threads can interleave freely. A separate report port charges a mispredict to a run. A run stops answering probes once its charges reach a limit.

Top module: `seq_run_table`

## Requirements
- R1: After reset, no probe reports a stored run. The response-valid output is low in every cycle that follows a cycle without a probe.
- R2: Three commits on one thread produce a stored run whose end address is the closing branch's PC, and probes of the start address then hit. The commits are a taken branch to address A, then a not-taken branch, then a taken branch at PC P.
- R3: A run closed with no not-taken commit inside it is not stored as complete, so a probe of its start address reports neither stored nor hit.
- R4: Each thread's open run is tracked separately. A not-taken commit on one thread never completes a run that another thread opened.
- R5: Each entry has a 4-bit miss counter that saturates at 15. A report on a run's start address raises that counter. At 3 or more charges a probe reports stored but no hit, while at 0 to 2 charges it still hits.
- R6: The set index is the low log2(SETS) address bits and the tag is the remaining bits. A start address not yet present takes a way chosen by a per-set round-robin pointer, starting at way 0. The new entry starts with no armed mark, no completion and zero misses, and it displaces whatever run held that way.
- R7: A probe's result appears exactly one cycle after the request. It already reflects any commit or report presented in the same cycle as the probe.
- R8: Reopening a start address that is already present keeps its stored end address. Only a later armed close replaces that address with the new closing PC.
- R9: A miss report for an address with no entry changes no stored run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_valid | input | 1 | A branch commits this cycle |
| cm_tid | input | TID_W | Thread of the committing branch |
| cm_pc | input | ADDR_W | Address of the committing branch |
| cm_target | input | ADDR_W | Target of the committing branch |
| cm_taken | input | 1 | Committed direction, 1 = taken |
| ms_valid | input | 1 | Mispredict charge this cycle |
| ms_addr | input | ADDR_W | Start address of the charged run |
| lk_req | input | 1 | Probe request |
| lk_addr | input | ADDR_W | Speculative taken target to probe |
| lk_rsp_valid | output | 1 | Probe response present |
| lk_hit | output | 1 | Stored run usable (complete and under the miss limit) |
| lk_built | output | 1 | Stored run complete, regardless of misses |
| lk_tail | output | ADDR_W | End address of the run, zero without a stored run |

## Verification
The bench builds the table with 12-bit addresses, 4 sets of 4 ways and 2 threads, and keeps the miss limit at 3. With only four sets, a handful of distinct start addresses fills one set, so round-robin displacement of a completed run comes within reach. Two threads are enough to interleave open runs and show that they stay separate. The narrow addresses let the start, closing and miss addresses be chosen by hand, so that they land in chosen sets and collide in a set only where that is intended.

// File: rtl/srt_pkg.sv
package srt_pkg;

  // A run answers probes only when complete and charged fewer than limit times.
  function automatic logic entry_live(logic done, int unsigned misses, int unsigned limit);
    return done && (misses < limit);
  endfunction

  // Saturating charge counter step.
  function automatic int unsigned miss_bump(int unsigned misses, int unsigned ceiling);
    return (misses >= ceiling) ? misses : misses + 1;
  endfunction

endpackage

// File: rtl/srt_way_match.sv
module srt_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0]             used,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        any,
  output logic [WAY_W-1:0]            way
);

  always_comb begin
    way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = used[w] && (tags[w] == key);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) way = WAY_W'(w);
    end
  end

  assign any = |hit_vec;

  // R6: allocation only takes a way when the tag is absent, so a set never holds a tag twice
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));

endmodule

// File: rtl/srt_victim.sv
module srt_victim #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] q_set,
  input  logic             adv,
  output logic [WAY_W-1:0] way
);

  logic [WAY_W-1:0] ptr [SETS];

  assign way = ptr[q_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr[s] <= '0;
    end else if (adv) begin
      ptr[q_set] <= (ptr[q_set] == WAY_W'(WAYS - 1)) ? '0 : ptr[q_set] + 1'b1;
    end
  end

endmodule

// File: rtl/seq_run_table.sv
module seq_run_table #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int THREADS    = 4,
  parameter int MISS_W     = 4,
  parameter int MISS_LIMIT = 3,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cm_valid,
  input  logic [TID_W-1:0]  cm_tid,
  input  logic [ADDR_W-1:0] cm_pc,
  input  logic [ADDR_W-1:0] cm_target,
  input  logic              cm_taken,
  input  logic              ms_valid,
  input  logic [ADDR_W-1:0] ms_addr,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_rsp_valid,
  output logic              lk_hit,
  output logic              lk_built,
  output logic [ADDR_W-1:0] lk_tail
);

  localparam int NQ = 3;  // 0: probe, 1: commit target, 2: miss report

  // Entry storage
  logic [TAG_W-1:0]  e_tag   [SETS][WAYS];
  logic              e_used  [SETS][WAYS];
  logic              e_armed [SETS][WAYS];
  logic              e_done  [SETS][WAYS];
  logic [MISS_W-1:0] e_miss  [SETS][WAYS];
  logic [ADDR_W-1:0] e_tail  [SETS][WAYS];

  // Per-thread open run
  logic [THREADS-1:0] p_act;
  logic [IDX_W-1:0]   p_set [THREADS];
  logic [WAY_W-1:0]   p_way [THREADS];
  logic [TAG_W-1:0]   p_tag [THREADS];

  // Registered probe
  logic              lk_q_vld;
  logic [ADDR_W-1:0] lk_q_addr;

  // Tag search ports
  logic [IDX_W-1:0]             q_set  [NQ];
  logic [TAG_W-1:0]             q_key  [NQ];
  logic [WAYS-1:0][TAG_W-1:0]   q_tags [NQ];
  logic [WAYS-1:0]              q_used [NQ];
  logic [WAYS-1:0]              q_vec  [NQ];
  logic [NQ-1:0]                q_any;
  logic [WAY_W-1:0]             q_way  [NQ];

  assign q_set[0] = lk_q_addr[IDX_W-1:0];
  assign q_key[0] = lk_q_addr[ADDR_W-1:IDX_W];
  assign q_set[1] = cm_target[IDX_W-1:0];
  assign q_key[1] = cm_target[ADDR_W-1:IDX_W];
  assign q_set[2] = ms_addr[IDX_W-1:0];
  assign q_key[2] = ms_addr[ADDR_W-1:IDX_W];

  always_comb begin
    for (int g = 0; g < NQ; g++) begin
      for (int w = 0; w < WAYS; w++) begin
        q_tags[g][w] = e_tag[q_set[g]][w];
        q_used[g][w] = e_used[q_set[g]][w];
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_search
    srt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .tags    (q_tags[g]),
      .used    (q_used[g]),
      .key     (q_key[g]),
      .hit_vec (q_vec[g]),
      .any     (q_any[g]),
      .way     (q_way[g])
    );
  end

  // Named internal events
  logic [IDX_W-1:0] cur_set;
  logic [WAY_W-1:0] cur_way;
  logic             pend_ok, fall_ev, term_ev, open_ev, alloc_ev, miss_ev;
  logic [WAY_W-1:0] vic_way, open_way;

  assign cur_set  = p_set[cm_tid];
  assign cur_way  = p_way[cm_tid];
  assign pend_ok  = p_act[cm_tid] && e_used[cur_set][cur_way]
                    && (e_tag[cur_set][cur_way] == p_tag[cm_tid]);
  assign fall_ev  = cm_valid && !cm_taken && pend_ok;
  assign term_ev  = cm_valid && cm_taken && pend_ok && e_armed[cur_set][cur_way];
  assign open_ev  = cm_valid && cm_taken;
  assign alloc_ev = open_ev && !q_any[1];
  assign open_way = q_any[1] ? q_way[1] : vic_way;
  assign miss_ev  = ms_valid && q_any[2];

  srt_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .q_set (q_set[1]),
    .adv   (alloc_ev),
    .way   (vic_way)
  );

  // Storage update: later statements win on a shared slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          e_tag[s][w]   <= '0;
          e_used[s][w]  <= 1'b0;
          e_armed[s][w] <= 1'b0;
          e_done[s][w]  <= 1'b0;
          e_miss[s][w]  <= '0;
          e_tail[s][w]  <= '0;
        end
      end
    end else begin
      if (miss_ev) begin
        e_miss[q_set[2]][q_way[2]] <= MISS_W'(srt_pkg::miss_bump(
          32'(e_miss[q_set[2]][q_way[2]]), (1 << MISS_W) - 1));
      end
      if (fall_ev) e_armed[cur_set][cur_way] <= 1'b1;
      if (term_ev) begin
        e_tail[cur_set][cur_way] <= cm_pc;
        e_done[cur_set][cur_way] <= 1'b1;
      end
      if (open_ev) begin
        e_armed[q_set[1]][open_way] <= 1'b0;
        if (alloc_ev) begin
          e_tag[q_set[1]][open_way]  <= q_key[1];
          e_used[q_set[1]][open_way] <= 1'b1;
          e_done[q_set[1]][open_way] <= 1'b0;
          e_miss[q_set[1]][open_way] <= '0;
        end
      end
    end
  end

  // Open-run pointers and probe register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_act     <= '0;
      lk_q_vld  <= 1'b0;
      lk_q_addr <= '0;
      for (int t = 0; t < THREADS; t++) begin
        p_set[t] <= '0;
        p_way[t] <= '0;
        p_tag[t] <= '0;
      end
    end else begin
      lk_q_vld  <= lk_req;
      lk_q_addr <= lk_addr;
      if (open_ev) begin
        p_act[cm_tid] <= 1'b1;
        p_set[cm_tid] <= q_set[1];
        p_way[cm_tid] <= open_way;
        p_tag[cm_tid] <= q_key[1];
      end
    end
  end

  // Probe response
  assign lk_rsp_valid = lk_q_vld;
  assign lk_built     = lk_q_vld && q_any[0] && e_done[q_set[0]][q_way[0]];
  assign lk_hit       = lk_built && srt_pkg::entry_live(1'b1,
                          32'(e_miss[q_set[0]][q_way[0]]), MISS_LIMIT);
  assign lk_tail      = lk_built ? e_tail[q_set[0]][q_way[0]] : '0;

  // R7: a response follows every accepted probe one cycle later
  p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_req) && $past(rst_n)) |-> lk_rsp_valid);

  // R8: a stored end address of a repeatedly probed run moves only after a commit
  p_tail_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_built && $past(lk_built) && (lk_q_addr == $past(lk_q_addr)) && !$past(cm_valid))
    |-> $stable(lk_tail));

  // R4: a taken commit leaves its own thread with an open run
  for (genvar t = 0; t < THREADS; t++) begin : g_open_chk
    p_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && cm_taken && (cm_tid == TID_W'(t))) |=> p_act[t]);
  end

endmodule

// File: tb/seq_run_table_tb_top.sv
module seq_run_table_tb_top;

  localparam int ADDR_W = 12;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int THR    = 2;
  localparam int MISS_W = 4;
  localparam int LIMIT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cm_valid = 1'b0, cm_taken = 1'b0, ms_valid = 1'b0, lk_req = 1'b0;
  logic [0:0] cm_tid = '0;
  logic [ADDR_W-1:0] cm_pc = '0, cm_target = '0, ms_addr = '0, lk_addr = '0;
  logic lk_rsp_valid, lk_hit, lk_built;
  logic [ADDR_W-1:0] lk_tail;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  seq_run_table #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .THREADS(THR),
                  .MISS_W(MISS_W), .MISS_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_tid(cm_tid), .cm_pc(cm_pc),
    .cm_target(cm_target), .cm_taken(cm_taken), .ms_valid(ms_valid), .ms_addr(ms_addr),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
    .lk_built(lk_built), .lk_tail(lk_tail));

  // Behavioural reference: runs keyed by set and slot, plus per-thread open run
  int m_used[SETS][WAYS], m_tag[SETS][WAYS], m_arm[SETS][WAYS];
  int m_done[SETS][WAYS], m_miss[SETS][WAYS], m_tail[SETS][WAYS];
  int m_rr[SETS];
  int o_act[THR], o_set[THR], o_way[THR], o_tag[THR];
  int x_rsp, x_hit, x_built, x_tail;

  function automatic int find(int s, int t);
    for (int w = 0; w < WAYS; w++) if (m_used[s][w] != 0 && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_used[s][w] = 0; m_tag[s][w] = 0; m_arm[s][w] = 0;
        m_done[s][w] = 0; m_miss[s][w] = 0; m_tail[s][w] = 0;
      end
    end
    for (int t = 0; t < THR; t++) begin o_act[t] = 0; o_set[t] = 0; o_way[t] = 0; o_tag[t] = 0; end
    x_rsp = 0; x_hit = 0; x_built = 0; x_tail = 0;
  endtask

  task automatic model_step();
    int cs, ct, ow, ms, mt, mw, tid, ok;
    cs = int'(cm_target) % SETS; ct = int'(cm_target) / SETS; ow = find(cs, ct);
    ms = int'(ms_addr) % SETS;   mt = int'(ms_addr) / SETS;   mw = find(ms, mt);
    tid = int'(cm_tid);
    ok = (o_act[tid] != 0 && m_used[o_set[tid]][o_way[tid]] != 0 &&
          m_tag[o_set[tid]][o_way[tid]] == o_tag[tid]) ? 1 : 0;
    if (ms_valid && mw >= 0 && m_miss[ms][mw] < 15) m_miss[ms][mw]++;
    if (cm_valid && !cm_taken && ok != 0) m_arm[o_set[tid]][o_way[tid]] = 1;
    if (cm_valid && cm_taken) begin
      if (ok != 0 && m_arm[o_set[tid]][o_way[tid]] != 0) begin
        m_tail[o_set[tid]][o_way[tid]] = int'(cm_pc);
        m_done[o_set[tid]][o_way[tid]] = 1;
      end
      if (ow >= 0) m_arm[cs][ow] = 0;
      else begin
        ow = m_rr[cs]; m_rr[cs] = (m_rr[cs] + 1) % WAYS;
        m_used[cs][ow] = 1; m_tag[cs][ow] = ct; m_arm[cs][ow] = 0;
        m_done[cs][ow] = 0; m_miss[cs][ow] = 0;
      end
      o_act[tid] = 1; o_set[tid] = cs; o_way[tid] = ow; o_tag[tid] = ct;
    end
    x_rsp = lk_req ? 1 : 0; x_hit = 0; x_built = 0; x_tail = 0;
    if (lk_req) begin
      int ls, lw;
      ls = int'(lk_addr) % SETS; lw = find(ls, int'(lk_addr) / SETS);
      if (lw >= 0 && m_done[ls][lw] != 0) begin
        x_built = 1; x_tail = m_tail[ls][lw];
        x_hit = (m_miss[ls][lw] < LIMIT) ? 1 : 0;
      end
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One clock: model follows the edge, outputs compared 2 ns after it
  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    #2;
    chk("R7", "rsp_valid", int'(lk_rsp_valid), x_rsp);
    if (x_rsp != 0) begin
      chk("R2", "model hit", int'(lk_hit), x_hit);
      chk("R2", "model built", int'(lk_built), x_built);
      chk("R2", "model tail", int'(lk_tail), x_tail);
    end
    cm_valid = 0; cm_taken = 0; ms_valid = 0; lk_req = 0;
  endtask

  task automatic commit(int tid, int pc, int tgt, bit tk);
    cm_valid = 1; cm_tid = 1'(tid); cm_pc = ADDR_W'(pc); cm_target = ADDR_W'(tgt); cm_taken = tk;
  endtask
  task automatic probe(int a); lk_req = 1; lk_addr = ADDR_W'(a); endtask
  task automatic charge(int a); ms_valid = 1; ms_addr = ADDR_W'(a); endtask

  task automatic expect_lk(string req, int hit, int built, int tail);
    chk(req, "hit", int'(lk_hit), hit);
    chk(req, "built", int'(lk_built), built);
    chk(req, "tail", int'(lk_tail), tail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: idle cycle, then empty probe
    tick(); chk("R1", "idle rsp_valid", int'(lk_rsp_valid), 0);
    probe('h105); tick(); expect_lk("R1", 0, 0, 0);

    // R2: open 0x105, fall through, close at 0x120
    commit(0, 'h010, 'h105, 1); tick();
    commit(0, 'h108, 'h10C, 0); tick();
    commit(0, 'h120, 'h202, 1); tick();
    probe('h105); tick(); expect_lk("R2", 1, 1, 'h120);

    // R3: 0x202 closed without a not-taken branch
    commit(0, 'h210, 'h303, 1); tick();
    probe('h202); tick(); expect_lk("R3", 0, 0, 0);

    // R4 / R7: interleaved threads; probe issued with the closing commit
    commit(0, 'h310, 'h400, 1); tick();
    commit(1, 'h050, 'h501, 1); tick();
    commit(1, 'h504, 'h508, 0); tick();
    commit(0, 'h410, 'h602, 1); tick();
    probe('h400); tick(); expect_lk("R4", 0, 0, 0);
    commit(1, 'h520, 'h703, 1); probe('h501); tick(); expect_lk("R7", 1, 1, 'h520);

    // R6: fill set 3 and displace by round robin
    commit(1, 'h708, 'h70C, 0); tick();
    commit(1, 'h710, 'h00B, 1); tick();
    commit(1, 'h0C0, 'h013, 1); tick();
    probe('h703); tick(); expect_lk("R6", 1, 1, 'h710);
    commit(1, 'h0D0, 'h017, 1); tick();
    probe('h703); tick(); expect_lk("R6", 1, 1, 'h710);
    commit(1, 'h0E0, 'h01B, 1); tick();
    probe('h703); tick(); expect_lk("R6", 0, 0, 0);

    // R5: charges against 0x105
    charge('h105); tick();
    charge('h105); tick();
    probe('h105); tick(); expect_lk("R5", 1, 1, 'h120);
    charge('h105); probe('h105); tick(); expect_lk("R5", 0, 1, 'h120);
    for (int i = 0; i < 14; i++) begin charge('h105); tick(); end
    probe('h105); tick(); expect_lk("R5", 0, 1, 'h120);

    // R9: charges to an absent start address in the same set as 0x501
    for (int i = 0; i < 3; i++) begin charge('h901); tick(); end
    probe('h501); tick(); expect_lk("R9", 1, 1, 'h520);

    // R8: reopen 0x501 without a fall, then with one
    commit(1, 'h060, 'h501, 1); tick();
    commit(1, 'h530, 'h800, 1); tick();
    probe('h501); tick(); expect_lk("R8", 1, 1, 'h520);
    commit(1, 'h070, 'h501, 1); tick();
    commit(1, 'h534, 'h538, 0); tick();
    commit(1, 'h540, 'h900, 1); probe('h501); tick(); expect_lk("R8", 1, 1, 'h540);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule